// File: doc/BRIEF.md
# Segmentable Up-Counter with Split Test Mode

This block is a 16-bit synchronous up-counter meant to serve as the counting core of any timer or event counter on a chip. In normal operation it advances by one on every clock where the count enable is high. It rolls over from all ones to zero after 65536 enabled cycles. A synchronous load replaces the count with a supplied value, and a synchronous reset clears it.

For production test, a split-mode input cuts the carry chain at every nibble boundary. The counter then acts as four independent 4-bit counters that all step together on each enabled clock. Every bit of the register toggles through its full range within 16 cycles instead of 65536. A terminal-count flag reports the all-ones state in either mode. Every counter and timer in the surrounding design is expected to use this core, so all of them split the same way under test. The control pins are plain level signals with no handshake, because no data stream enters or leaves the block.

Top module: `segmentable_counter`

## Requirements
- R1: When `srst` is high at a rising edge, `count` becomes 16'h0000 after that edge, whatever `ld` and `cnt_en` are.
- R2: When `ld` is high and `srst` is low at a rising edge, `count` takes `ld_val` after that edge, whatever `cnt_en` and `split` are.
- R3: When `srst`, `ld` and `cnt_en` are all low at a rising edge, `count` keeps its value.
- R4: With `split` low, an enabled edge (`cnt_en` high, `ld` and `srst` low) adds one to the 16-bit count modulo 65536, so carries ripple across nibble boundaries (16'h00FF becomes 16'h0100 and 16'hFFFF becomes 16'h0000).
- R5: With `split` high, an enabled edge adds one modulo 16 to each nibble count[3:0], count[7:4], count[11:8] and count[15:12] separately, and no carry passes between nibbles (16'h0F0F becomes 16'h1010).
- R6: `tc` is high exactly when `count` equals 16'hFFFF, which is also the state where every nibble is 4'hF. This holds in both modes, and `tc` follows `count` in the same cycle with no extra register.
- R7: Changing `split` does not alter `count` by itself. The new mode governs only the increments made at the following enabled edges.
- R8: In split mode, 16 consecutive enabled edges bring `count` back to its starting value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| srst | input | 1 | Synchronous reset, active high, highest priority |
| cnt_en | input | 1 | Count enable |
| ld | input | 1 | Synchronous load strobe, priority over counting |
| ld_val | input | 16 | Value written by a load |
| split | input | 1 | 1 = four independent 4-bit counters, 0 = one 16-bit counter |
| count | output | 16 | Current count value |
| tc | output | 1 | Terminal count, high when every bit of `count` is one |

## Verification
The assertions assume that every control input and `ld_val` hold known 0/1 values at each rising edge and change only away from it. They also assume that `srst` is applied at least once before results are judged. The stepping properties compare `count` with its value one cycle earlier, so they rely on the reset having defined the register. The bench drives all inputs on the falling edge and starts with a reset cycle that also holds `ld` and `cnt_en` high. Between any two edges it changes `split`, `ld` and `cnt_en` freely, including mode changes on cycles where the count is held, so each priority and mode-switch case is exercised inside those assumptions.

// File: rtl/seg_cnt_pkg.sv
package seg_cnt_pkg;

  // Width of one independently countable segment.
  parameter int unsigned SEG_W = 4;

  // Operating modes of the carry network.
  typedef enum logic {
    MODE_WIDE  = 1'b0,   // full-length carry chain
    MODE_SPLIT = 1'b1    // carry cut at each segment boundary
  } cnt_mode_e;

  // Decode the split pin into a mode value.
  function automatic cnt_mode_e mode_of(input logic split_pin);
    return split_pin ? MODE_SPLIT : MODE_WIDE;
  endfunction

endpackage

// File: rtl/seg_cnt_carry.sv
module seg_cnt_carry #(
  parameter int unsigned NUM_SEG = 4
) (
  input  logic                 en,
  input  seg_cnt_pkg::cnt_mode_e mode,
  input  logic [NUM_SEG-1:0]   seg_full,
  output logic [NUM_SEG-1:0]   seg_inc
);
  import seg_cnt_pkg::*;

  // Segment 0 always steps on the enable. Higher segments step on the
  // carry-out of the segment below in wide mode, or on the enable alone
  // in split mode.
  assign seg_inc[0] = en;

  for (genvar i = 1; i < NUM_SEG; i++) begin : g_gate
    logic chain_carry;
    assign chain_carry = seg_inc[i-1] & seg_full[i-1];
    assign seg_inc[i]  = (mode == MODE_SPLIT) ? en : chain_carry;
  end

endmodule

// File: rtl/seg_cnt_slice.sv
module seg_cnt_slice #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         ld,
  input  logic [W-1:0] ld_seg,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         full
);
  localparam logic [W-1:0] STEP = W'(1);

  always_ff @(posedge clk) begin
    if (srst)      q <= '0;
    else if (ld)   q <= ld_seg;
    else if (inc)  q <= q + STEP;
  end

  assign full = &q;

  // A stepped segment advances by exactly one, wrapping inside its width.
  AST_SLICE_STEP: assert property (@(posedge clk) disable iff (srst)
    (!ld && inc) |=> (q == $past(q) + STEP));                           // R5

  // A segment with no step and no load keeps its value.
  AST_SLICE_HOLD: assert property (@(posedge clk) disable iff (srst)
    (!ld && !inc) |=> $stable(q));                                      // R3

endmodule

// File: rtl/seg_cnt_term.sv
module seg_cnt_term #(
  parameter int unsigned NUM_SEG = 4
) (
  input  logic [NUM_SEG-1:0] seg_full,
  output logic               tc
);
  // All segments at their maximum means the full word is all ones.
  assign tc = &seg_full;
endmodule

// File: rtl/segmentable_counter.sv
module segmentable_counter #(
  parameter int unsigned SEG_W   = seg_cnt_pkg::SEG_W,
  parameter int unsigned NUM_SEG = 4
) (
  input  logic                     clk,
  input  logic                     srst,
  input  logic                     cnt_en,
  input  logic                     ld,
  input  logic [SEG_W*NUM_SEG-1:0] ld_val,
  input  logic                     split,
  output logic [SEG_W*NUM_SEG-1:0] count,
  output logic                     tc
);
  import seg_cnt_pkg::*;

  localparam int unsigned CNT_W = SEG_W * NUM_SEG;
  localparam logic [CNT_W-1:0] ONE_W = CNT_W'(1);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  cnt_mode_e          mode;
  logic [NUM_SEG-1:0] seg_full;
  logic [NUM_SEG-1:0] seg_inc;

  assign mode = mode_of(split);

  seg_cnt_carry #(.NUM_SEG(NUM_SEG)) u_carry (
    .en       (cnt_en),
    .mode     (mode),
    .seg_full (seg_full),
    .seg_inc  (seg_inc)
  );

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    seg_cnt_slice #(.W(SEG_W)) u_slice (
      .clk    (clk),
      .srst   (srst),
      .ld     (ld),
      .ld_seg (ld_val[s*SEG_W +: SEG_W]),
      .inc    (seg_inc[s]),
      .q      (count[s*SEG_W +: SEG_W]),
      .full   (seg_full[s])
    );

    // In split mode each segment steps on the enable alone.
    AST_SPLIT_SEG_STEP: assert property (@(posedge clk) disable iff (srst)
      (split && cnt_en && !ld) |=>
        (count[s*SEG_W +: SEG_W] ==
         $past(count[s*SEG_W +: SEG_W]) + SEG_W'(1)));                 // R5
  end

  seg_cnt_term #(.NUM_SEG(NUM_SEG)) u_term (
    .seg_full (seg_full),
    .tc       (tc)
  );

  // ---------------- port-level properties ----------------
  AST_RESET_CLEARS: assert property (@(posedge clk)
    srst |=> (count == '0));                                            // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (srst)
    ld |=> (count == $past(ld_val)));                                   // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (srst)
    (!ld && !cnt_en) |=> $stable(count));                               // R3

  AST_WIDE_STEP: assert property (@(posedge clk) disable iff (srst)
    (!split && cnt_en && !ld) |=> (count == $past(count) + ONE_W));     // R4

  AST_TC_MATCH: assert property (@(posedge clk) disable iff (srst)
    tc == (count == ALL_ONES));                                         // R6

endmodule

// File: tb/segmentable_counter_tb.sv
module segmentable_counter_tb;

  localparam int CNT_W = 16;
  localparam int WATCHDOG_CYCLES = 5000;

  logic             clk = 1'b0;
  logic             srst = 1'b0;
  logic             cnt_en = 1'b0;
  logic             ld = 1'b0;
  logic [CNT_W-1:0] ld_val = '0;
  logic             split = 1'b0;
  logic [CNT_W-1:0] count;
  logic             tc;

  always #10 clk = ~clk;   // 50 MHz

  segmentable_counter u_dut (
    .clk    (clk),
    .srst   (srst),
    .cnt_en (cnt_en),
    .ld     (ld),
    .ld_val (ld_val),
    .split  (split),
    .count  (count),
    .tc     (tc)
  );

  typedef struct {
    logic [CNT_W-1:0] cnt;
    logic             tc;
    string            tag;
  } exp_t;

  exp_t expq[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  logic [CNT_W-1:0] model = '0;
  bit   done = 1'b0;

  // Reference model of one clock edge, written from the requirements.
  function automatic logic [CNT_W-1:0] next_val(
      input logic [CNT_W-1:0] cur, input logic r, input logic l,
      input logic [CNT_W-1:0] lv, input logic e, input logic sp);
    logic [CNT_W-1:0] n;
    if (r)       n = '0;
    else if (l)  n = lv;
    else if (!e) n = cur;
    else if (!sp) n = cur + 16'd1;
    else begin
      n = cur;
      for (int k = 0; k < 4; k++) n[k*4 +: 4] = cur[k*4 +: 4] + 4'd1;
    end
    return n;
  endfunction

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard.
  task automatic drive(input logic r, input logic l, input logic [CNT_W-1:0] lv,
                       input logic e, input logic sp, input string tag);
    exp_t item;
    @(negedge clk);
    srst = r; ld = l; ld_val = lv; cnt_en = e; split = sp;
    model = next_val(model, r, l, lv, e, sp);
    item.cnt = model;
    item.tc  = (model == 16'hFFFF);
    item.tag = tag;
    expq.push_back(item);
  endtask

  // Monitor: pops after each rising edge and compares away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expq.size() > 0) begin
        exp_t it;
        it = expq.pop_front();
        n_checks++;
        if (count !== it.cnt) begin
          n_fails++;
          $display("FAIL %s: count actual %h expected %h", it.tag, count, it.cnt);
        end
        n_checks++;
        if (tc !== it.tc) begin
          n_fails++;
          $display("FAIL R6 (%s): tc actual %b expected %b", it.tag, tc, it.tc);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R1: reset wins over load and enable.
    drive(1, 1, 16'hABCD, 1, 0, "R1");
    drive(1, 0, 16'h0000, 1, 1, "R1");
    // R2: load with enable high, both modes.
    drive(0, 1, 16'h1234, 1, 0, "R2");
    drive(0, 1, 16'h5678, 1, 1, "R2");
    // R3: hold with enable low.
    drive(0, 0, 16'h0000, 0, 0, "R3");
    drive(0, 0, 16'hFFFF, 0, 0, "R3");
    // R7: toggling split while idle leaves the count alone.
    drive(0, 0, 16'h0000, 0, 1, "R7");
    drive(0, 0, 16'h0000, 0, 0, "R7");
    // R4: carry across a nibble boundary.
    drive(0, 1, 16'h00FF, 0, 0, "R2");
    drive(0, 0, 16'h0000, 1, 0, "R4");
    // R4/R6: approach and wrap through all ones.
    drive(0, 1, 16'hFFFE, 0, 0, "R2");
    drive(0, 0, 16'h0000, 1, 0, "R6");
    drive(0, 0, 16'h0000, 1, 0, "R4");
    // R5: no carry between nibbles in split mode.
    drive(0, 1, 16'h0F0F, 0, 1, "R2");
    drive(0, 0, 16'h0000, 1, 1, "R5");
    // R6: tc with every nibble at F in split mode, then split step away.
    drive(0, 1, 16'hFFFF, 0, 1, "R6");
    drive(0, 1, 16'hEFFF, 0, 1, "R6");
    drive(0, 0, 16'h0000, 1, 1, "R5");
    // R7: switch mode between enabled steps; new mode used at next edge.
    drive(0, 1, 16'h0EFF, 0, 0, "R2");
    drive(0, 0, 16'h0000, 1, 1, "R7");
    drive(0, 0, 16'h0000, 1, 0, "R7");
    // R8: 16 split steps return to start.
    drive(0, 1, 16'h3A7C, 0, 1, "R2");
    for (int i = 0; i < 16; i++) drive(0, 0, 16'h0000, 1, 1, "R8");
    // R1: reset mid-count.
    drive(1, 0, 16'h0000, 1, 0, "R1");
    drive(0, 0, 16'h0000, 0, 0, "R3");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule